// File: doc/BRIEF.md
# Random Bit Generator Seed Collector

This block gathers the seed for the random bit generator that drives the decryption engine's countermeasures. Software writes the seed one byte per bus write to a single data word. The block keeps a read-only progress counter. Software reads it to learn which byte index the block expects next.

Each accepted byte goes into a slot of an internal seed buffer. When all sixteen slots are filled, the counter stops at sixteen and a valid flag goes high. After that the buffer is frozen until reset. Software may not change the seed while the surrounding controller is enabled. The block therefore refuses every data write while the controller-enable input is high.

The bus port is a simple single-cycle word interface. A write strobe is qualified by a byte address, and read data is returned combinationally for the address presented.

Top module: `rng_seed_loader`

## Requirements
- R1: After reset the counter reads 0, `seed_valid` is 0 and `seed_value` is all zeros.
- R2: A write to the data word (byte address 0x0) with `ctrl_en` low and the counter below 16 is accepted. The counter rises by one at that clock edge, so a read of the counter word (byte address 0x4) in the next cycle returns the new value in bits [4:0], with all higher bits zero.
- R3: An accepted byte is stored in the slot whose index equals the counter value before the increment. Slot i appears on `seed_value[8*i+7:8*i]`.
- R4: Only `bus_wdata[7:0]` of an accepted write is stored, and bits [31:8] have no effect.
- R5: While `ctrl_en` is high, data writes are refused: the counter and `seed_value` stay unchanged.
- R6: Once the counter reads 16, further data writes are refused and the counter stays at 16.
- R7: `seed_valid` rises at the same clock edge that accepts the sixteenth byte, so it is high in the following cycle. It then stays high regardless of `ctrl_en` or later writes until reset.
- R8: A write to the counter word changes nothing, and a read of the data word returns zero.
- R9: Reset applied partway through a load clears the counter, the buffer and `seed_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_en | input | 1 | Controller enabled; blocks seed writes while high |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Byte address: 0x0 data word, 0x4 counter word |
| bus_wdata | input | 32 | Write data; low byte carries the seed byte |
| bus_rdata | output | 32 | Read data for `bus_addr` (counter word or zero) |
| seed_valid | output | 1 | All seed bytes collected |
| seed_value | output | 128 | Collected seed, slot i in bits [8*i+7:8*i] |

## Verification
Several rules are checked by properties on every cycle:
- the counter never exceeds sixteen;
- every write that should be accepted advances the counter by exactly one;
- a write made while the controller is enabled leaves the counter untouched;
- the valid flag never drops outside reset and matches a full counter.

Only the bench scenarios can show the following:
- each byte lands in the correct buffer slot;
- the upper write bits are discarded;
- writes to the counter word leave all state alone;
- a mid-load reset clears the partly filled buffer.

// File: rtl/seed_loader_pkg.sv
package seed_loader_pkg;
   // Register selected by the decoded bus address
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_DATA  = 2'd1,
      SEL_COUNT = 2'd2
   } seed_reg_sel_e;
endpackage

// File: rtl/seed_reg_decode.sv
module seed_reg_decode
   import seed_loader_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_OFS = 0,
   parameter int CNT_OFS  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output seed_reg_sel_e     sel
);
   always_comb begin
      if (addr == ADDR_W'(DATA_OFS))
         sel = SEL_DATA;
      else if (addr == ADDR_W'(CNT_OFS))
         sel = SEL_COUNT;
      else
         sel = SEL_NONE;
   end
endmodule

// File: rtl/seed_fill_counter.sv
module seed_fill_counter #(
   parameter int SEED_BYTES = 16,
   parameter int CNT_W      = $clog2(SEED_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             valid
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SEED_BYTES - 1);

   assign full = (count == CNT_W'(SEED_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         valid <= 1'b0;
      end else if (take) begin
         count <= count + 1'b1;
         if (count == LAST)
            valid <= 1'b1;
      end
   end
endmodule

// File: rtl/seed_byte_store.sv
module seed_byte_store #(
   parameter int SEED_BYTES = 16,
   parameter int BYTE_W     = 8,
   parameter int CNT_W      = $clog2(SEED_BYTES + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         take,
   input  logic [CNT_W-1:0]             slot,
   input  logic [BYTE_W-1:0]            byte_in,
   output logic [SEED_BYTES*BYTE_W-1:0] seed_flat
);
   for (genvar i = 0; i < SEED_BYTES; i++) begin : g_slot
      logic [BYTE_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= '0;
         else if (take && (slot == CNT_W'(i)))
            cell_q <= byte_in;
      end
      assign seed_flat[i*BYTE_W +: BYTE_W] = cell_q;
   end
endmodule

// File: rtl/rng_seed_loader.sv
module rng_seed_loader
   import seed_loader_pkg::*;
#(
   parameter int SEED_BYTES = 16,
   parameter int BYTE_W     = 8,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int DATA_OFS   = 0,
   parameter int CNT_OFS    = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ctrl_en,
   input  logic                         bus_wr,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   output logic                         seed_valid,
   output logic [SEED_BYTES*BYTE_W-1:0] seed_value
);
   localparam int CNT_W = $clog2(SEED_BYTES + 1);

   // Elaboration-time parameter checks
   if (DATA_W < BYTE_W) begin : g_bad_width
      $error("DATA_W must hold at least one seed byte");
   end
   if (DATA_W <= CNT_W) begin : g_bad_cnt
      $error("DATA_W must be wider than the fill counter");
   end
   if (DATA_OFS == CNT_OFS) begin : g_bad_map
      $error("data and counter words need distinct offsets");
   end
   if (SEED_BYTES < 2) begin : g_bad_depth
      $error("SEED_BYTES must be at least 2");
   end

   seed_reg_sel_e    reg_sel;
   logic [CNT_W-1:0] fill_cnt;
   logic             fill_full;
   logic             wr_data_hit;
   logic             byte_take;

   seed_reg_decode #(
      .ADDR_W  (ADDR_W),
      .DATA_OFS(DATA_OFS),
      .CNT_OFS (CNT_OFS)
   ) u_dec (
      .addr(bus_addr),
      .sel (reg_sel)
   );

   assign wr_data_hit = bus_wr && (reg_sel == SEL_DATA);
   assign byte_take   = wr_data_hit && !ctrl_en && !fill_full;

   seed_fill_counter #(
      .SEED_BYTES(SEED_BYTES),
      .CNT_W     (CNT_W)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .take (byte_take),
      .count(fill_cnt),
      .full (fill_full),
      .valid(seed_valid)
   );

   seed_byte_store #(
      .SEED_BYTES(SEED_BYTES),
      .BYTE_W    (BYTE_W),
      .CNT_W     (CNT_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (byte_take),
      .slot     (fill_cnt),
      .byte_in  (bus_wdata[BYTE_W-1:0]),
      .seed_flat(seed_value)
   );

   // Upper write bits are deliberately discarded
   logic wdata_unused_hi;
   assign wdata_unused_hi = ^bus_wdata[DATA_W-1:BYTE_W];

   always_comb begin
      if (reg_sel == SEL_COUNT)
         bus_rdata = {{(DATA_W-CNT_W){1'b0}}, fill_cnt};
      else
         bus_rdata = '0;
   end
endmodule

// File: rtl/rng_seed_loader_chk.sv
module rng_seed_loader_chk #(
   parameter int SEED_BYTES = 16,
   parameter int CNT_W      = $clog2(SEED_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_en,
   input logic             data_hit,
   input logic [CNT_W-1:0] count,
   input logic             seed_valid
);
   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(SEED_BYTES));

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hit && !ctrl_en && (count < CNT_W'(SEED_BYTES)))
         |=> (count == $past(count) + 1'b1));

   // R5
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hit && ctrl_en) |=> $stable(count));

   // R7
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_valid |=> seed_valid);

   // R7
   valid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_valid == (count == CNT_W'(SEED_BYTES)));
endmodule

bind rng_seed_loader rng_seed_loader_chk #(
   .SEED_BYTES(SEED_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_en   (ctrl_en),
   .data_hit  (wr_data_hit),
   .count     (fill_cnt),
   .seed_valid(seed_valid)
);

// File: tb/rng_seed_loader_test.sv
module rng_seed_loader_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_DATA = 4'h0;
   localparam logic [3:0] A_CNT  = 4'h4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctrl_en = 1'b0;
   logic         bus_wr = 1'b0;
   logic [3:0]   bus_addr = 4'h0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         seed_valid;
   logic [127:0] seed_value;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   // scoreboard queues: kind 0 = read data, 1 = seed value, 2 = valid flag
   logic [127:0] q_exp[$];
   int           q_kind[$];
   string        q_tag[$];
   event         sample_ev;

   logic [127:0] exp_seed;

   rng_seed_loader uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_en   (ctrl_en),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .seed_valid(seed_valid),
      .seed_value(seed_value)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: pops expected items and compares with the outputs
   initial begin
      forever begin
         @(sample_ev);
         while (q_exp.size() > 0) begin
            logic [127:0] e;
            logic [127:0] a;
            int k;
            string t;
            e = q_exp.pop_front();
            k = q_kind.pop_front();
            t = q_tag.pop_front();
            if (k == 0)      a = {96'd0, bus_rdata};
            else if (k == 1) a = seed_value;
            else             a = {127'd0, seed_valid};
            checks++;
            if (a !== e) begin
               fails++;
               $display("FAIL %s actual=%0h expected=%0h", t, a, e);
            end
         end
      end
   end

   task automatic push_exp(input int kind, input logic [127:0] e, input string tag);
      q_exp.push_back(e);
      q_kind.push_back(kind);
      q_tag.push_back(tag);
      ->sample_ev;
      #1;
   endtask

   task automatic read_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
      bus_addr = a;
      #1;
      push_exp(0, {96'd0, e}, tag);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      exp_seed = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      read_chk(A_CNT, 32'd0, "R1 counter after reset");
      push_exp(1, 128'd0, "R1 seed after reset");
      push_exp(2, 128'd0, "R1 valid after reset");

      // R2 R3 R4 first byte with junk upper bits
      wr(A_DATA, 32'hABCD_EF11);
      exp_seed[7:0] = 8'h11;
      read_chk(A_CNT, 32'd1, "R2 counter after first byte");
      push_exp(1, exp_seed, "R3 R4 slot 0 holds low byte only");

      // R5 refused while controller enabled
      ctrl_en = 1'b1;
      wr(A_DATA, 32'h0000_0022);
      read_chk(A_CNT, 32'd1, "R5 counter held while enabled");
      push_exp(1, exp_seed, "R5 seed held while enabled");
      ctrl_en = 1'b0;

      // R8 write to counter word and read of data word
      wr(A_CNT, 32'h0000_0033);
      read_chk(A_CNT, 32'd1, "R8 counter word write ignored");
      push_exp(1, exp_seed, "R8 seed unchanged by counter write");
      read_chk(A_DATA, 32'd0, "R8 data word reads zero");

      // R2 R3 remaining bytes
      for (int i = 1; i < 16; i++) begin
         logic [7:0] b;
         b = 8'h40 + 8'(i);
         wr(A_DATA, {24'hC3C3C3, b});
         exp_seed[i*8 +: 8] = b;
         if (i == 8) read_chk(A_CNT, 32'd9, "R2 counter mid load");
         if (i == 14) begin
            read_chk(A_CNT, 32'd15, "R2 counter before last byte");
            push_exp(2, 128'd0, "R7 valid low before last byte");
         end
      end
      read_chk(A_CNT, 32'd16, "R2 counter full");
      push_exp(2, 128'd1, "R7 valid after sixteenth byte");
      push_exp(1, exp_seed, "R3 full seed layout");

      // R6 extra write refused
      wr(A_DATA, 32'h0000_0099);
      read_chk(A_CNT, 32'd16, "R6 counter stays at 16");
      push_exp(1, exp_seed, "R6 seed frozen");

      // R7 valid sticky across ctrl_en
      ctrl_en = 1'b1;
      repeat (3) @(negedge clk);
      ctrl_en = 1'b0;
      @(negedge clk);
      push_exp(2, 128'd1, "R7 valid stays high");

      // R9 reset after full and during partial load
      do_reset();
      read_chk(A_CNT, 32'd0, "R9 counter cleared");
      push_exp(2, 128'd0, "R9 valid cleared");
      wr(A_DATA, 32'h0000_00A1);
      wr(A_DATA, 32'h0000_00A2);
      wr(A_DATA, 32'h0000_00A3);
      read_chk(A_CNT, 32'd3, "R2 counter partial load");
      push_exp(1, 128'h00A3A2A1, "R3 partial seed");
      do_reset();
      read_chk(A_CNT, 32'd0, "R9 counter cleared mid load");
      push_exp(1, 128'd0, "R9 seed cleared mid load");

      @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule